// File: doc/BRIEF.md
# ADC result window comparator

This block sits behind an ADC and looks at every conversion result it produces. Each result comes with a valid strobe and a 5-bit tag naming the analog input it came from. The result is compared as an unsigned 32-bit word against a low and a high threshold. Each threshold is 16 bits wide and is zero-extended before the compare. Five relations can be enabled one by one: below low, at or above low, below high, at or above high, and inside the window (low inclusive, high exclusive). When any enabled relation holds for a valid result, a sticky event flag is set. On the first such event since the flag was last cleared, the input tag is captured.

Software reaches the block through a small register port. Reads are combinational and writes take effect on the clock edge. Reading the capture register returns the tag and clears the event flag. Turning the comparator off also clears the event flag. An interrupt output follows the event flag while the interrupt enable is set.

Tag codes 0 to 22 name inputs 0 to 22, and code 31 is reserved. The block stores whatever tag it receives.

Top module: `adc_wcmp`

## Requirements
- R1: After reset every register field reads 0, and irq_o is 0.
- R2: Register map. Address 0 is control: bit 0 enable, bit 1 interrupt enable, bits 6:2 relation enables, bit 8 event flag (read-only). Relation enables are bit 2 below-low, bit 3 at-or-above-low, bit 4 below-high, bit 5 at-or-above-high, bit 6 window. Address 1 holds the thresholds: bits 15:0 low, bits 31:16 high. Address 2 is capture: bits 4:0 captured tag, bit 8 event flag. Address 3 reads 0.
- R3: The below-low relation holds when data < low. The at-or-above-low relation holds when low <= data.
- R4: The below-high relation holds when data < high. The at-or-above-high relation holds when high <= data.
- R5: The window relation holds when low <= data < high.
- R6: Thresholds are zero-extended to 32 bits and compared unsigned. For example, data 0x0001_0050 is not below a low of 100.
- R7: A result is evaluated only in a cycle where res_valid_i is 1 and the enable bit is 1. Otherwise it has no effect.
- R8: If any enabled relation holds for an evaluated result, the event flag is 1 from the next cycle on and stays set. The tag is captured only when the flag was clear, so later events keep the first tag.
- R9: A read of address 2 clears the event flag at the clock edge. If an event arrives in the same cycle, the flag stays 1 and the new tag is captured.
- R10: A write of 0 to the enable bit clears the event flag at that edge, and this wins over an event arriving in the same cycle.
- R11: irq_o equals the event flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | Result strobe |
| res_data_i | input | 32 | Conversion result |
| res_ain_i | input | 5 | Input tag of the result |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (read side effects) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| irq_o | output | 1 | Interrupt |

## Verification
The bench tests every relation one cycle either side of each threshold. A design that swapped `<` for `<=` would flag or miss exactly at the boundary value. A result with bits above bit 15 set shows whether the thresholds are zero-extended; a design that truncated the data would see a small value there. Two events in a row check that the first tag is held, and a read that lands together with a new event checks that the event wins. A design that gave the read priority would lose that event. A disable written in the same cycle as a hit must leave the flag clear.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_THR  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CAPT = 2'd2;

  localparam int NCOND = 5;
  typedef enum int {
    REL_LT_LO = 0,
    REL_GE_LO = 1,
    REL_LT_HI = 2,
    REL_GE_HI = 3,
    REL_WIN   = 4
  } rel_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_REL  = 2;
  localparam int STAT_EVT  = 8;
endpackage

// File: rtl/adc_wcmp_eval.sv
module adc_wcmp_eval
  import adc_wcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 16
) (
  input  logic              valid_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [THR_W-1:0]  lo_i,
  input  logic [THR_W-1:0]  hi_i,
  input  logic [NCOND-1:0]  rel_en_i,
  output logic              hit_o
);
  localparam int PAD_W = DATA_W - THR_W;

  logic [DATA_W-1:0] lo_x, hi_x;
  logic [NCOND-1:0]  rel;

  assign lo_x = {{PAD_W{1'b0}}, lo_i};
  assign hi_x = {{PAD_W{1'b0}}, hi_i};

  always_comb begin
    rel            = '0;
    rel[REL_LT_LO] = data_i < lo_x;
    rel[REL_GE_LO] = data_i >= lo_x;
    rel[REL_LT_HI] = data_i < hi_x;
    rel[REL_GE_HI] = data_i >= hi_x;
    rel[REL_WIN]   = (data_i >= lo_x) && (data_i < hi_x);
  end

  assign hit_o = valid_i & en_i & |(rel & rel_en_i);

  always_comb begin
    if (!(valid_i && en_i)) assert_no_eval_R7: assert (!hit_o);
  end
endmodule

// File: rtl/adc_wcmp_regs.sv
module adc_wcmp_regs
  import adc_wcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 16,
  parameter int ID_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              evt_i,
  input  logic [ID_W-1:0]   id_i,
  output logic              en_o,
  output logic              ie_o,
  output logic [NCOND-1:0]  rel_en_o,
  output logic [THR_W-1:0]  lo_o,
  output logic [THR_W-1:0]  hi_o,
  output logic              dis_o,
  output logic              clr_o,
  output logic [31:0]       rdata_o
);
  logic wr_ctrl, wr_thr;
  logic unused_wdata;

  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_thr  = we_i && (addr_i == ADDR_THR);
  assign dis_o   = wr_ctrl && !wdata_i[CTRL_EN];
  assign clr_o   = re_i && (addr_i == ADDR_CAPT);
  assign unused_wdata = ^wdata_i[31:CTRL_REL+NCOND];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      ie_o     <= 1'b0;
      rel_en_o <= '0;
      lo_o     <= '0;
      hi_o     <= '0;
    end else begin
      if (wr_ctrl) begin
        en_o     <= wdata_i[CTRL_EN];
        ie_o     <= wdata_i[CTRL_IE];
        rel_en_o <= wdata_i[CTRL_REL +: NCOND];
      end
      if (wr_thr) begin
        lo_o <= wdata_i[THR_W-1:0];
        hi_o <= wdata_i[2*THR_W-1:THR_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]              = en_o;
        rdata_o[CTRL_IE]              = ie_o;
        rdata_o[CTRL_REL +: NCOND]    = rel_en_o;
        rdata_o[STAT_EVT]             = evt_i;
      end
      ADDR_THR:  rdata_o[2*THR_W-1:0] = {hi_o, lo_o};
      ADDR_CAPT: begin
        rdata_o[ID_W-1:0]             = id_i;
        rdata_o[STAT_EVT]             = evt_i;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_wcmp_event.sv
module adc_wcmp_event #(
  parameter int ID_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hit_i,
  input  logic            dis_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] ain_i,
  output logic            evt_o,
  output logic [ID_W-1:0] id_o
);
  logic capture;

  // capture only on a fresh event; a same-cycle read counts as fresh
  assign capture = hit_i && !dis_i && (!evt_o || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o <= 1'b0;
      id_o  <= '0;
    end else begin
      if (dis_i)      evt_o <= 1'b0;
      else if (hit_i) evt_o <= 1'b1;
      else if (clr_i) evt_o <= 1'b0;
      if (capture)    id_o  <= ain_i;
    end
  end

  assert_hit_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !dis_i) |=> evt_o);
  assert_id_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !clr_i) |=> $stable(id_o));
  assert_read_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !evt_o);
  assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && hit_i && !dis_i) |=> (evt_o && id_o == $past(ain_i)));
  assert_disable_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_i |=> !evt_o);
endmodule

// File: rtl/adc_wcmp.sv
module adc_wcmp
  import adc_wcmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 16,
  parameter int ID_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              res_valid_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [ID_W-1:0]   res_ain_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic             en, ie, dis, clr, hit, evt;
  logic [NCOND-1:0] rel_en;
  logic [THR_W-1:0] lo, hi;
  logic [ID_W-1:0]  id;

  adc_wcmp_regs #(.DATA_W(DATA_W), .THR_W(THR_W), .ID_W(ID_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .evt_i(evt), .id_i(id),
    .en_o(en), .ie_o(ie), .rel_en_o(rel_en), .lo_o(lo), .hi_o(hi),
    .dis_o(dis), .clr_o(clr), .rdata_o(reg_rdata_o)
  );

  adc_wcmp_eval #(.DATA_W(DATA_W), .THR_W(THR_W)) u_eval (
    .valid_i(res_valid_i), .en_i(en), .data_i(res_data_i),
    .lo_i(lo), .hi_i(hi), .rel_en_i(rel_en), .hit_o(hit)
  );

  adc_wcmp_event #(.ID_W(ID_W)) u_event (
    .clk_i, .rst_ni,
    .hit_i(hit), .dis_i(dis), .clr_i(clr), .ain_i(res_ain_i),
    .evt_o(evt), .id_o(id)
  );

  assign irq_o = evt & ie;

  assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !irq_o);
  assert_irq_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie && evt) |-> irq_o);
  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!irq_o && reg_rdata_o[STAT_EVT] == 1'b0));
endmodule

// File: tb/adc_wcmp_test.sv
module adc_wcmp_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] data = '0;
  logic [4:0]  ain = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0, cyc = 0;

  // behavioural reference
  bit      m_en, m_ie, m_evt;
  bit [4:0] m_rel;
  int      m_lo, m_hi;
  int      m_id;

  adc_wcmp uut (
    .clk_i(clk), .rst_ni(rst_n),
    .res_valid_i(valid), .res_data_i(data), .res_ain_i(ain),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  always #5 clk = ~clk;

  function automatic longint unsigned model_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_en + 2 * m_ie + 4 * m_rel + 256 * m_evt;
      2'd1: return m_lo + 65536 * m_hi;
      2'd2: return m_id + 256 * m_evt;
      default: return 0;
    endcase
  endfunction

  function automatic bit model_hit(input longint unsigned d);
    bit h = 0;
    if (m_rel[0] && d <  m_lo) h = 1;
    if (m_rel[1] && d >= m_lo) h = 1;
    if (m_rel[2] && d <  m_hi) h = 1;
    if (m_rel[3] && d >= m_hi) h = 1;
    if (m_rel[4] && d >= m_lo && d < m_hi) h = 1;
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_evt = 0; m_rel = 0; m_lo = 0; m_hi = 0; m_id = 0;
    end else begin
      bit hit, dis, clr;
      hit = valid && m_en && model_hit(longint'(data));
      dis = we && addr == 2'd0 && !wdata[0];
      clr = re && addr == 2'd2;
      if (hit && !dis && (!m_evt || clr)) m_id = int'(ain);
      if (dis) m_evt = 0;
      else if (hit) m_evt = 1;
      else if (clr) m_evt = 0;
      if (we && addr == 2'd0) begin
        m_en = wdata[0]; m_ie = wdata[1]; m_rel = wdata[6:2];
      end
      if (we && addr == 2'd1) begin
        m_lo = int'(wdata[15:0]); m_hi = int'(wdata[31:16]);
      end
    end
  end

  // every-cycle comparison against the model (R2, R8, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (rdata != 32'(model_rd(addr)) || irq != (m_evt && m_ie)) begin
        fails++;
        $display("FAIL R8/R11 cycle %0d: rdata=%h irq=%0b expected rdata=%h irq=%0b",
                 cyc, rdata, irq, 32'(model_rd(addr)), m_evt && m_ie);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0; addr = 2'd0; wdata = '0;
  endtask

  // read: value checked at the negedge before the side-effect edge
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    re = 1; addr = a;
    @(negedge clk); v = rdata;
    @(posedge clk); #1;
    re = 0; addr = 2'd0;
  endtask

  task automatic push(input logic [31:0] d, input logic [4:0] t);
    @(posedge clk); #1;
    valid = 1; data = d; ain = t;
    @(posedge clk); #1;
    valid = 0; data = '0; ain = '0;
  endtask

  // one relation enabled, one result, event flag checked
  task automatic probe(input string tag, input logic [4:0] rel, input logic [31:0] d,
                       input logic exp);
    logic [31:0] v;
    wr(2'd0, {25'd0, rel, 2'b01});
    rd(2'd2, v);
    push(d, 5'd7);
    rd(2'd2, v);
    chk(tag, {31'd0, v[8]}, {31'd0, exp});
    if (exp) chk({tag, " id"}, {27'd0, v[4:0]}, 32'd7);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl reset", rdata, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rd(2'd1, v); chk("R1 thr reset", v, 32'd0);
    rd(2'd2, v); chk("R1 capt reset", v, 32'd0);

    wr(2'd1, {16'd200, 16'd100});
    rd(2'd1, v); chk("R2 thr readback", v, 32'h00C8_0064);
    wr(2'd0, 32'h0000_0043);
    rd(2'd0, v); chk("R2 ctrl readback", v, 32'h0000_0043);
    rd(2'd3, v); chk("R2 addr3 zero", v, 32'd0);

    probe("R3 lt_lo 99",  5'b00001, 32'd99,  1'b1);
    probe("R3 lt_lo 100", 5'b00001, 32'd100, 1'b0);
    probe("R3 ge_lo 100", 5'b00010, 32'd100, 1'b1);
    probe("R3 ge_lo 99",  5'b00010, 32'd99,  1'b0);
    probe("R4 lt_hi 199", 5'b00100, 32'd199, 1'b1);
    probe("R4 lt_hi 200", 5'b00100, 32'd200, 1'b0);
    probe("R4 ge_hi 200", 5'b01000, 32'd200, 1'b1);
    probe("R4 ge_hi 199", 5'b01000, 32'd199, 1'b0);
    probe("R5 win 100",   5'b10000, 32'd100, 1'b1);
    probe("R5 win 199",   5'b10000, 32'd199, 1'b1);
    probe("R5 win 200",   5'b10000, 32'd200, 1'b0);
    probe("R5 win 99",    5'b10000, 32'd99,  1'b0);
    probe("R6 zext lt_lo", 5'b00001, 32'h0001_0050, 1'b0);
    probe("R6 zext ge_hi", 5'b01000, 32'h0001_0050, 1'b1);

    // R7: no strobe, then comparator off
    wr(2'd0, 32'h0000_0005);
    rd(2'd2, v);
    @(posedge clk); #1; data = 32'd5; ain = 5'd2;
    @(posedge clk); #1; data = '0; ain = '0;
    rd(2'd0, v); chk("R7 no valid no event", {31'd0, v[8]}, 32'd0);
    wr(2'd0, 32'h0000_0004);
    push(32'd5, 5'd2);
    rd(2'd0, v); chk("R7 disabled no event", {31'd0, v[8]}, 32'd0);

    // R8: first tag held across later events, OR of relations
    wr(2'd0, 32'h0000_0025);
    push(32'd5, 5'd4);
    push(32'd900, 5'd9);
    rd(2'd2, v); chk("R8 first tag held", v, 32'h0000_0104);
    rd(2'd2, v); chk("R8 cleared after read", {31'd0, v[8]}, 32'd0);
    push(32'd900, 5'd22);
    rd(2'd0, v); chk("R8 ge_hi via OR", {31'd0, v[8]}, 32'd1);

    // R9: read and event in the same cycle
    @(posedge clk); #1;
    re = 1; addr = 2'd2; valid = 1; data = 32'd3; ain = 5'd17;
    @(posedge clk); #1;
    re = 0; addr = 2'd0; valid = 0; data = '0; ain = '0;
    rd(2'd2, v); chk("R9 event wins over read", v, 32'h0000_0111);

    // R11: interrupt gating
    push(32'd3, 5'd1);
    @(negedge clk); chk("R11 irq off while ie=0", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'h0000_0027);
    @(negedge clk); chk("R11 irq on", {31'd0, irq}, 32'd1);

    // R10: disable clears, and wins over a same-cycle hit
    wr(2'd0, 32'h0000_0026);
    @(negedge clk); chk("R10 disable clears", rdata, 32'h0000_0026);
    chk("R10 irq drops", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'h0000_0027);
    push(32'd3, 5'd5);
    @(posedge clk); #1;
    we = 1; addr = 2'd0; wdata = 32'h0000_0026; valid = 1; data = 32'd3; ain = 5'd6;
    @(posedge clk); #1;
    we = 0; wdata = '0; valid = 0; data = '0; ain = '0;
    @(negedge clk); chk("R10 disable beats hit", {31'd0, rdata[8]}, 32'd0);

    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule